// File: doc/BRIEF.md
# Pipelined Binomial Cube Unit

This unit raises an unsigned N-bit operand to the third power. The operand is cut into an upper half `a` and a lower half `b`, each N/2 bits wide. The unit never runs two full-width multiplications in a row. Instead it builds the cube from a row of four terms that form a geometric progression: `a^3`, `a^2*b`, `a*b^2` and `b^3`. A second row then adds doubled copies of the two middle terms, which brings each middle coefficient up to three.

Each term is shifted by the binary weight of its half-word position, and all terms are summed into a 3N-bit result that can never overflow. The work is split over two register stages. The first stage forms the half-width squares and the cross product. The second stage forms the row terms and the weighted sum. A new operand may enter on every clock.

Top module: `cube_binom`

## Requirements
- R1: When `valid_o` is high, `cube_o` equals the full 3N-bit value m*m*m, where m is the operand that was presented with `valid_i` high two clocks earlier. The result is never truncated.
- R2: `valid_o` is high in exactly those cycles where `valid_i` was high two rising edges earlier. It is low in all other cycles.
- R3: While `rst_ni` is low, `valid_o` is low. Asserting `rst_ni` low drops `valid_o` at once and discards every operand still in flight.
- R4: An operand of 0 yields a cube of 0.
- R5: The all-ones operand 2^N-1 yields (2^N-1)^3, which uses the full 3N-bit width.
- R6: Operands presented on consecutive clocks each produce a result. The results come out in the order the operands went in, one per clock.
- R7: An operand whose lower half (bits N/2-1..0) is zero yields a^3 shifted left by 3N/2 bits. An operand whose upper half is zero yields b^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| m_i | input | N | Unsigned operand; upper half is a, lower half is b |
| valid_i | input | 1 | Operand qualifier |
| cube_o | output | 3N | Unsigned cube of the operand from two clocks earlier |
| valid_o | output | 1 | Result qualifier |

## Verification
The bench pushes all 2^N operands back to back. This covers zero, all-ones, and every operand with one half zeroed. A design that forgets the doubled middle row, or that gives a term the wrong weight, produces wrong cubes exactly where both halves are nonzero. A design that truncates the sum fails at all-ones. The bench also leaves gaps in `valid_i` and pulls reset while operands are in flight. A valid pipeline of the wrong depth, or one that is not cleared, shows up as a result at the wrong latency or an unexpected result after reset.

// File: rtl/cube_pkg.sv
package cube_pkg;
  localparam int unsigned CUBE_W_DEF = 8;
  localparam int unsigned CUBE_LAT   = 2;
  // binomial coefficient per term: a^3, a^2b, ab^2, b^3
  function automatic int unsigned row_coef(input int unsigned k);
    return (k == 0 || k == 3) ? 1 : 3;
  endfunction
endpackage

// File: rtl/cube_part_prod.sv
module cube_part_prod #(
  parameter int unsigned N = cube_pkg::CUBE_W_DEF,
  localparam int unsigned H = N / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] m_i,
  input  logic         valid_i,
  output logic [H-1:0] a_o,
  output logic [H-1:0] b_o,
  output logic [N-1:0] aa_o,
  output logic [N-1:0] ab_o,
  output logic [N-1:0] bb_o,
  output logic         valid_o
);
  logic [H-1:0] a_w, b_w;
  assign a_w = m_i[N-1:H];
  assign b_w = m_i[H-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;

  always_ff @(posedge clk_i) begin
    a_o  <= a_w;
    b_o  <= b_w;
    aa_o <= N'(a_w) * N'(a_w);
    ab_o <= N'(a_w) * N'(b_w);
    bb_o <= N'(b_w) * N'(b_w);
  end
endmodule

// File: rtl/cube_row_sum.sv
module cube_row_sum #(
  parameter int unsigned N = cube_pkg::CUBE_W_DEF,
  localparam int unsigned H = N / 2,
  localparam int unsigned W = 3 * N,
  localparam int unsigned T = 3 * H
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [H-1:0] a_i,
  input  logic [H-1:0] b_i,
  input  logic [N-1:0] aa_i,
  input  logic [N-1:0] ab_i,
  input  logic [N-1:0] bb_i,
  input  logic         valid_i,
  output logic [W-1:0] cube_o,
  output logic         valid_o
);
  logic [T-1:0] term [4];
  logic [W-1:0] wtd  [4];
  logic [W-1:0] acc  [4];

  // geometric row: a^3, a^2b, ab^2, b^3
  assign term[0] = T'(aa_i) * T'(a_i);
  assign term[1] = T'(aa_i) * T'(b_i);
  assign term[2] = T'(ab_i) * T'(b_i);
  assign term[3] = T'(bb_i) * T'(b_i);

  for (genvar k = 0; k < 4; k++) begin : g_term
    if (cube_pkg::row_coef(k) == 3) begin : g_mid
      // top row plus doubled second row
      assign wtd[k] = (W'(term[k]) + (W'(term[k]) << 1)) << ((3 - k) * H);
    end else begin : g_end
      assign wtd[k] = W'(term[k]) << ((3 - k) * H);
    end
    if (k == 0) begin : g_a0
      assign acc[k] = wtd[k];
    end else begin : g_an
      assign acc[k] = acc[k-1] + wtd[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;

  always_ff @(posedge clk_i) cube_o <= acc[3];
endmodule

// File: rtl/cube_binom.sv
module cube_binom #(
  parameter int unsigned N = cube_pkg::CUBE_W_DEF,
  localparam int unsigned H = N / 2,
  localparam int unsigned W = 3 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] m_i,
  input  logic         valid_i,
  output logic [W-1:0] cube_o,
  output logic         valid_o
);
  logic [H-1:0] a_q, b_q;
  logic [N-1:0] aa_q, ab_q, bb_q;
  logic         v_q;

  cube_part_prod #(.N(N)) u_prod (
    .clk_i, .rst_ni, .m_i, .valid_i,
    .a_o(a_q), .b_o(b_q), .aa_o(aa_q), .ab_o(ab_q), .bb_o(bb_q), .valid_o(v_q)
  );

  cube_row_sum #(.N(N)) u_sum (
    .clk_i, .rst_ni,
    .a_i(a_q), .b_i(b_q), .aa_i(aa_q), .ab_i(ab_q), .bb_i(bb_q), .valid_i(v_q),
    .cube_o, .valid_o
  );
endmodule

// File: rtl/cube_binom_chk.sv
module cube_binom_chk #(
  parameter int unsigned N = cube_pkg::CUBE_W_DEF,
  localparam int unsigned H = N / 2,
  localparam int unsigned W = 3 * N
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] m_i,
  input logic         valid_i,
  input logic [W-1:0] cube_o,
  input logic         valid_o
);
  logic [N-1:0] m_d1, m_d2;
  logic         v_d1, v_d2;
  logic [W-1:0] mw, ref_cube, aw, a_cube;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) {v_d1, v_d2} <= 2'b00;
    else         {v_d1, v_d2} <= {valid_i, v_d1};

  always_ff @(posedge clk_i) begin
    m_d1 <= m_i;
    m_d2 <= m_d1;
  end

  always_comb begin
    mw       = W'(m_d2);
    ref_cube = mw * mw * mw;
    aw       = W'(m_d2[N-1:H]);
    a_cube   = (aw * aw * aw) << (3 * H);
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_d2);
  // R3
  rst_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);
  // R1
  cube_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cube_o == ref_cube);
  // R4
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && m_d2 == '0) |-> cube_o == '0);
  // R5
  max_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && m_d2 == '1) |-> cube_o[W-1]);
  // R7
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && m_d2[H-1:0] == '0) |-> cube_o == a_cube);
endmodule

bind cube_binom cube_binom_chk #(.N(N)) u_chk (
  .clk_i, .rst_ni, .m_i, .valid_i, .cube_o, .valid_o
);

// File: tb/cube_binom_tb_top.sv
`timescale 1ns/1ps
module cube_binom_tb_top;
  localparam int unsigned N = 8;
  localparam int unsigned H = N / 2;
  localparam int unsigned W = 3 * N;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] m_i = '0;
  logic         valid_i = 1'b0;
  logic [W-1:0] cube_o;
  logic         valid_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [W-1:0] q_exp[$];
  logic [N-1:0] q_m[$];
  int           q_cyc[$];

  cube_binom #(.N(N)) dut_i (.clk_i, .rst_ni, .m_i, .valid_i, .cube_o, .valid_o);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [W-1:0] ref_cube(input logic [N-1:0] m);
    logic [W-1:0] x;
    x = W'(m);
    return x * x * x;
  endfunction

  task automatic drive(input logic [N-1:0] m, input logic v);
    @(negedge clk_i);
    m_i = m;
    valid_i = v;
    if (v) begin
      q_exp.push_back(ref_cube(m));
      q_m.push_back(m);
      q_cyc.push_back(cyc);
    end
  endtask

  // monitor: 5 ns after each rising edge
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && valid_o && !done) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected valid_o: actual 1 expected 0");
      end else begin
        logic [W-1:0] e;
        logic [N-1:0] m;
        int c;
        string tag;
        e = q_exp.pop_front();
        m = q_m.pop_front();
        c = q_cyc.pop_front();
        if (m == '0) tag = "R4";
        else if (m == '1) tag = "R5";
        else if (m[H-1:0] == '0 || m[N-1:H] == '0) tag = "R7";
        else tag = "R1";
        if (cube_o !== e) begin
          errors++;
          $display("FAIL %s m=%0d: actual %0d expected %0d", tag, m, cube_o, e);
        end
        checks++;
        // R6: in-order, one per clock, latency two
        if (cyc - c != 2) begin
          errors++;
          $display("FAIL R2 latency m=%0d: actual %0d expected 2", m, cyc - c);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 reset state valid_o: actual %b expected 0", valid_o);
    end
    rst_ni = 1'b1;

    // R1 R4 R5 R6 R7: every operand back to back
    for (int i = 0; i < (1 << N); i++) drive(N'(i), 1'b1);
    drive('0, 1'b0);

    // R2: gaps between operands
    for (int i = 0; i < 40; i++) drive(N'(i * 37 + 11), (i % 3) != 1);
    repeat (4) drive('0, 1'b0);

    // R3: reset with operands in flight
    drive(8'hA5, 1'b1);
    drive(8'h5A, 1'b1);
    #1;
    rst_ni = 1'b0;
    q_exp.delete(); q_m.delete(); q_cyc.delete();
    valid_i = 1'b0;
    #1;
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 mid reset valid_o: actual %b expected 0", valid_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) drive('0, 1'b0);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 flushed valid_o: actual %b expected 0", valid_o);
    end

    // R5 R4 again after reset
    drive('1, 1'b1);
    drive('0, 1'b1);
    repeat (4) drive('0, 1'b0);

    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results: actual %0d expected 0", q_exp.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule